// File: doc/BRIEF.md
# Decimal Matrix Code Decoder

This block is a purely combinational read-side decoder for a 32-bit memory word protected by a decimal matrix code. The word is viewed logically as eight 4-bit symbols laid out in two rows of four columns: row 0 holds symbols 0 to 3 (data bits 15:0) and row 1 holds symbols 4 to 7 (data bits 31:16), with symbol s occupying bits 4s+3:4s. Each row carries two 5-bit horizontal checks, each the integer sum of two symbols of that row that are two columns apart. Sixteen vertical checks hold the XOR of the two data bits that share a column position.

On a read, the block recomputes both kinds of check from the received data. It subtracts each stored horizontal check from its recomputed sum modulo 32, and XORs the recomputed vertical checks with the stored ones. A nonzero horizontal syndrome marks the row and symbol pair that hold the damage. The vertical syndrome then gives the exact bits, which are inverted. In this way any burst that stays inside one row and shifts that pair's sum is repaired, however many bits it spans.

Top module: `dmc_decoder`

## Requirements
- R1: The stored horizontal check of pair p (p = 2r+g, bits 5p+4:5p of the horizontal field) is the 5-bit sum of symbols 4r+g and 4r+g+2. Stored vertical bit i is data bit i XOR data bit i+16. The horizontal syndrome is taken modulo 32, so a drop in a pair's sum (a wrap below zero) is detected and corrected just like a rise.
- R2: A consistent codeword gives error_detected=0 and uncorrectable=0, and corrected_data equals the received data.
- R3: Any single flipped data bit is corrected, with error_detected=1 and uncorrectable=0.
- R4: A multi-bit burst inside one symbol is corrected.
- R5: Flips in both symbols of one pair (non-adjacent columns of one row) are corrected.
- R6: Flips in both pairs of the same row are corrected.
- R7: Flips in row 0 in one column group (columns g, g+2) and in row 1 in the other group are both corrected.
- R8: When both rows show a nonzero horizontal syndrome in the same column group, uncorrectable=1, and corrected_data equals the received data.
- R9: A flipped stored horizontal bit gives error_detected=1 and uncorrectable=0, with the data unchanged.
- R10: A nonzero vertical syndrome in a column group where neither row has a nonzero horizontal syndrome gives uncorrectable=1, error_detected=0, and unchanged data. This covers a flipped stored vertical bit.
- R11: When every bit of both symbols of a pair is flipped and their sum is 15, the horizontal syndrome is zero. The result is error_detected=0 and the received (wrong) data passed through, with uncorrectable=1 by R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_data | input | 32 | Received data bits |
| rx_hchk | input | 20 | Received horizontal checks, four 5-bit sums |
| rx_vchk | input | 16 | Received vertical checks |
| corrected_data | output | 32 | Data after correction |
| error_detected | output | 1 | Some horizontal syndrome is nonzero |
| uncorrectable | output | 1 | Row clash or unexplained vertical syndrome; no correction applied |

## Verification
The bench targets row selection. A flip pair split across the rows in the same column group must raise uncorrectable, while the same split across different groups must be repaired. A decoder that mixed these up would either invert bits in the wrong row or refuse a correctable word. It also drives a sum that falls below the stored value, so a decoder that dropped the modulo wrap or compared with a signed result would miss it. Check-bit-only faults and the sum-15 escape are driven too, since a decoder that corrected from the vertical syndrome alone would corrupt good data or claim to have repaired the escape.

// File: rtl/dmc_decoder.sv
module dmc_decoder #(
  parameter int SYM_W = 4
) (
  input  logic [31:0] rx_data,
  input  logic [19:0] rx_hchk,
  input  logic [15:0] rx_vchk,
  output logic [31:0] corrected_data,
  output logic        error_detected,
  output logic        uncorrectable
);
  localparam int HW    = SYM_W + 1;
  localparam int ROW_W = 4 * SYM_W;

  logic [3:0][HW-1:0] hsyn;
  logic [3:0]         hflag;
  logic [ROW_W-1:0]   vsyn;
  logic [1:0]         vflag;
  logic [1:0]         clash;
  logic [1:0]         orphan;
  logic [31:0]        fix_mask;

  for (genvar p = 0; p < 4; p++) begin : g_pair
    localparam int R = p / 2;
    localparam int G = p % 2;
    logic [HW-1:0] sum;
    assign sum      = {1'b0, rx_data[(4*R+G)*SYM_W +: SYM_W]}
                    + {1'b0, rx_data[(4*R+G+2)*SYM_W +: SYM_W]};
    assign hsyn[p]  = sum - rx_hchk[p*HW +: HW];
    assign hflag[p] = |hsyn[p];
  end

  assign vsyn = rx_data[ROW_W-1:0] ^ rx_data[2*ROW_W-1:ROW_W] ^ rx_vchk;

  for (genvar g = 0; g < 2; g++) begin : g_group
    assign vflag[g]  = |vsyn[g*SYM_W +: SYM_W] | |vsyn[(g+2)*SYM_W +: SYM_W];
    assign clash[g]  = hflag[g] & hflag[g+2];
    assign orphan[g] = ~hflag[g] & ~hflag[g+2] & vflag[g];
  end

  assign uncorrectable  = |clash | |orphan;
  assign error_detected = |hflag;

  for (genvar s = 0; s < 8; s++) begin : g_sym
    localparam int R = s / 4;
    localparam int C = s % 4;
    localparam int P = 2 * R + (C % 2);
    assign fix_mask[s*SYM_W +: SYM_W] =
      (hflag[P] && !uncorrectable) ? vsyn[C*SYM_W +: SYM_W] : '0;
  end

  assign corrected_data = rx_data ^ fix_mask;

  always_comb begin
    if (!error_detected && !uncorrectable)
      assert_clean_pass_R2: assert (corrected_data == rx_data);
    if (uncorrectable)
      assert_hold_on_fail_R8: assert (corrected_data == rx_data);
    if (!uncorrectable)
      assert_vparity_restored_R1: assert ((corrected_data[15:0] ^ corrected_data[31:16]) == rx_vchk);
    assert_one_row_per_column_R7: assert (((corrected_data[15:0] ^ rx_data[15:0]) &
                                           (corrected_data[31:16] ^ rx_data[31:16])) == '0);
  end
endmodule

// File: tb/dmc_decoder_tb.sv
module dmc_decoder_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] rx_data;
  logic [19:0] rx_hchk;
  logic [15:0] rx_vchk;
  logic [31:0] corrected_data;
  logic        error_detected;
  logic        uncorrectable;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dmc_decoder u_dut (
    .rx_data(rx_data), .rx_hchk(rx_hchk), .rx_vchk(rx_vchk),
    .corrected_data(corrected_data), .error_detected(error_detected),
    .uncorrectable(uncorrectable)
  );

  function automatic logic [19:0] hcode(input logic [31:0] d);
    logic [19:0] h;
    for (int p = 0; p < 4; p++) begin
      int a;
      int b;
      a = 16 * (p / 2) + 4 * (p % 2);
      b = a + 8;
      h[p*5 +: 5] = 5'(d[a +: 4]) + 5'(d[b +: 4]);
    end
    return h;
  endfunction

  function automatic logic [15:0] vcode(input logic [31:0] d);
    return d[15:0] ^ d[31:16];
  endfunction

  task automatic apply(input logic [31:0] d, input logic [31:0] dflip,
                       input logic [19:0] hflip, input logic [15:0] vflip);
    @(negedge clk);
    rx_data = d ^ dflip;
    rx_hchk = hcode(d) ^ hflip;
    rx_vchk = vcode(d) ^ vflip;
    #2;
  endtask

  task automatic expect_out(input string req, input logic [31:0] ed,
                            input logic e_det, input logic e_unc);
    checks++;
    if (corrected_data !== ed || error_detected !== e_det || uncorrectable !== e_unc) begin
      fails++;
      $display("FAIL %s: got data=%h det=%b unc=%b, expected data=%h det=%b unc=%b",
               req, corrected_data, error_detected, uncorrectable, ed, e_det, e_unc);
    end
  endtask

  task automatic t_clean_R2();
    logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0F1E_2D3C};
    foreach (pats[i]) begin
      apply(pats[i], '0, '0, '0);
      expect_out("R2", pats[i], 1'b0, 1'b0);
    end
  endtask

  task automatic t_single_R3();
    for (int b = 0; b < 32; b++) begin
      logic [31:0] d;
      d = 32'hA5C3_96E1 ^ (32'h1 << ((b * 7) % 32));
      apply(d, 32'h1 << b, '0, '0);
      expect_out("R3", d, 1'b1, 1'b0);
    end
  endtask

  task automatic t_wrap_R1();
    logic [31:0] d = 32'h0000_0F0F;
    apply(d, 32'h0000_0505, '0, '0);
    expect_out("R1", d, 1'b1, 1'b0);
  endtask

  task automatic t_burst_R4();
    logic [31:0] d = 32'h1234_0567;
    apply(d, 32'h0000_F000, '0, '0);
    expect_out("R4", d, 1'b1, 1'b0);
  endtask

  task automatic t_pair_R5();
    logic [31:0] d = 32'h7777_F0F0;
    apply(d, 32'h0000_0906, '0, '0);
    expect_out("R5", d, 1'b1, 1'b0);
  endtask

  task automatic t_row_R6();
    logic [31:0] d = 32'h0000_ABCD;
    apply(d, 32'h0B57_0000, '0, '0);
    expect_out("R6", d, 1'b1, 1'b0);
  endtask

  task automatic t_split_R7();
    logic [31:0] d = 32'h0000_0000;
    apply(d, 32'h0050_0003, '0, '0);
    expect_out("R7", d, 1'b1, 1'b0);
  endtask

  task automatic t_clash_R8();
    logic [31:0] d = 32'h0000_0000;
    apply(d, 32'h0001_0001, '0, '0);
    expect_out("R8", d ^ 32'h0001_0001, 1'b1, 1'b1);
  endtask

  task automatic t_hbit_R9();
    logic [31:0] d = 32'h3C5A_9617;
    apply(d, '0, 20'h0_0080, '0);
    expect_out("R9", d, 1'b1, 1'b0);
  endtask

  task automatic t_vbit_R10();
    logic [31:0] d = 32'h3C5A_9617;
    apply(d, '0, '0, 16'h0020);
    expect_out("R10", d, 1'b0, 1'b1);
  endtask

  task automatic t_escape_R11();
    logic [31:0] d = 32'h0000_0906;
    apply(d, 32'h0000_0F0F, '0, '0);
    expect_out("R11", d ^ 32'h0000_0F0F, 1'b0, 1'b1);
  endtask

  initial begin
    rx_data = '0;
    rx_hchk = '0;
    rx_vchk = '0;
    t_clean_R2();
    t_wrap_R1();
    t_single_R3();
    t_burst_R4();
    t_pair_R5();
    t_row_R6();
    t_split_R7();
    t_clash_R8();
    t_hbit_R9();
    t_vbit_R10();
    t_escape_R11();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule